// File: doc/BRIEF.md
# Windowed Address Translation Unit

This block holds two banks of address translation windows, one for traffic entering the chip (inbound) and one for traffic leaving it (outbound). Software reaches every window through a single selector register. The selector picks a direction and a window index. A fixed group of window registers then addresses whichever window is selected. Each window stores a 64-bit base, a 32-bit limit, a 64-bit target, a type word and an enable bit.

Window settings are written into a staging copy. They reach the matching logic only when the window's second control word is written. Each lookup names a direction and a 64-bit address. The block compares the address with every committed window of that direction. If a window matches, the block returns the translated address, or for an outbound configuration window the bus number, device/function and register offset of a configuration access.

The unit sits between a register bus and the request path of a bus bridge. It does not produce transactions itself.

Top module: `addr_xlate_unit`

## Requirements
- R1: The selector register at offset 0x900 stores bit 31 as the direction (1 = inbound, 0 = outbound) and bits [3:0] as the window index. Every other bit of this register reads as 0.
- R2: The selected window's registers sit at these offsets and read back the value last written: type word 0x904, control word 0x908, base low 0x90C, base high 0x910, limit 0x914, target low 0x918, target high 0x91C.
- R3: A write to the low or the high word of the base or the target changes only that 32-bit half.
- R4: The matching logic uses the base, limit, target and type that a window had when its control word (0x908) was last written. Writes to the other window registers leave lookup results unchanged.
- R5: A committed window is enabled when bit 31 of its control word is set. It matches addresses from base through {base[63:32], limit}, both ends included. A memory match returns address − base + target.
- R6: When several enabled windows of the requested direction match, the lowest index wins, and rsp_win reports that index.
- R7: An outbound window whose type word is nonzero is a configuration window. A match sets rsp_cfg and returns bus = target[31:24], devfn = target[23:16] and offset = (address − base)[11:0], with rsp_addr = 0. Inbound windows always translate as memory windows, whatever their type word.
- R8: After reset, every window reads base 0, target 0, limit 0xFFFFFFFF, type 0 and control 0, and the selector reads 0. The one exception is inbound window 0: its control word reads 0x80000000 and it is committed enabled, so inbound addresses 0 to 0xFFFFFFFF pass through untranslated.
- R9: On a miss, rsp_hit, rsp_cfg, rsp_win, rsp_addr, rsp_bus, rsp_devfn and rsp_offset are all 0.
- R10: Results are registered. A request sampled at one rising edge produces rsp_valid = 1 and its result after that edge. An edge with no request gives rsp_valid = 0 and rsp_hit = 0.
- R11: When the selector index is 4 or higher (there are 4 windows per direction), the window registers read 0 and writes to them are ignored.
- R12: Register offsets outside 0x900 through 0x91C read 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr (combinational) |
| req_valid | input | 1 | Lookup request present |
| req_inbound | input | 1 | Lookup direction: 1 = inbound, 0 = outbound |
| req_addr | input | 64 | Lookup address |
| rsp_valid | output | 1 | Result of the request sampled at the previous edge |
| rsp_hit | output | 1 | A window matched |
| rsp_win | output | 2 | Index of the winning window |
| rsp_cfg | output | 1 | Match was on an outbound configuration window |
| rsp_addr | output | 64 | Translated memory address |
| rsp_bus | output | 8 | Configuration bus number |
| rsp_devfn | output | 8 | Configuration device/function |
| rsp_offset | output | 12 | Configuration register offset |

## Verification
A register write takes effect at the rising edge that captures it. Read data follows the current state combinationally, so the bench samples it 1 ns after setting the offset, in the same low phase. A lookup result is due exactly one rising edge after the request. The bench drives each request at a falling edge and compares every response field at the next falling edge, before the following edge can overwrite it. Commit timing is checked by looking up an address between a staging write and the control-word write, with expected results computed from the committed values only.

// File: rtl/axu_pkg.sv
package axu_pkg;
  localparam int unsigned AW  = 64;   // translated address width
  localparam int unsigned DW  = 32;   // register width
  localparam int unsigned RAW = 12;   // register offset width

  localparam logic [RAW-1:0] OFS_SELECT  = 12'h900;
  localparam logic [RAW-1:0] OFS_TYPE    = 12'h904;
  localparam logic [RAW-1:0] OFS_CTRL    = 12'h908;
  localparam logic [RAW-1:0] OFS_BASE_LO = 12'h90C;
  localparam logic [RAW-1:0] OFS_BASE_HI = 12'h910;
  localparam logic [RAW-1:0] OFS_LIMIT   = 12'h914;
  localparam logic [RAW-1:0] OFS_TGT_LO  = 12'h918;
  localparam logic [RAW-1:0] OFS_TGT_HI  = 12'h91C;

  localparam int unsigned    EN_BIT  = 31;
  localparam int unsigned    DIR_BIT = 31;
  localparam logic [DW-1:0]  EN_MASK = 32'h8000_0000;

  // staging copy, visible to software
  typedef struct packed {
    logic [AW-1:0] base;
    logic [DW-1:0] limit;
    logic [AW-1:0] target;
    logic [DW-1:0] kind;
    logic [DW-1:0] ctrl;
  } win_stage_t;

  // committed copy, seen by the matching logic
  typedef struct packed {
    logic          en;
    logic          is_cfg;
    logic [AW-1:0] base;
    logic [DW-1:0] limit;
    logic [AW-1:0] target;
  } win_live_t;
endpackage

// File: rtl/axu_regfile.sv
module axu_regfile
  import axu_pkg::*;
#(
  parameter int unsigned NUM_WIN = 4,
  parameter int unsigned SEL_W   = 4,
  localparam int unsigned WIN_W  = $clog2(NUM_WIN)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     reg_we,
  input  logic [RAW-1:0]           reg_addr,
  input  logic [DW-1:0]            reg_wdata,
  output logic [DW-1:0]            reg_rdata,
  output win_live_t [NUM_WIN-1:0]  live_in,
  output win_live_t [NUM_WIN-1:0]  live_out
);
  // direction index: 1 = inbound, 0 = outbound
  logic                                 sel_dir_q, sel_dir_d;
  logic [SEL_W-1:0]                     sel_idx_q, sel_idx_d;
  win_stage_t [1:0][NUM_WIN-1:0]        stg_q, stg_d;
  win_live_t  [1:0][NUM_WIN-1:0]        live_q, live_d;

  logic             sel_ok;
  logic [WIN_W-1:0] wsel;
  win_stage_t       cur;
  logic             win_reg;

  assign sel_ok  = (32'(sel_idx_q) < NUM_WIN);
  assign wsel    = sel_idx_q[WIN_W-1:0];
  assign cur     = stg_q[sel_dir_q][wsel];
  assign win_reg = (reg_addr >= OFS_TYPE) && (reg_addr <= OFS_TGT_HI) &&
                   (reg_addr[1:0] == 2'b00);

  // next state
  always_comb begin
    sel_dir_d = sel_dir_q;
    sel_idx_d = sel_idx_q;
    stg_d     = stg_q;
    live_d    = live_q;
    if (reg_addr == OFS_SELECT) begin
      sel_dir_d = reg_wdata[DIR_BIT];
      sel_idx_d = reg_wdata[SEL_W-1:0];
    end else if (sel_ok) begin
      case (reg_addr)
        OFS_TYPE:    stg_d[sel_dir_q][wsel].kind = reg_wdata;
        OFS_CTRL: begin
          stg_d[sel_dir_q][wsel].ctrl          = reg_wdata;
          live_d[sel_dir_q][wsel].en           = reg_wdata[EN_BIT];
          live_d[sel_dir_q][wsel].is_cfg       = (cur.kind != '0);
          live_d[sel_dir_q][wsel].base         = cur.base;
          live_d[sel_dir_q][wsel].limit        = cur.limit;
          live_d[sel_dir_q][wsel].target       = cur.target;
        end
        OFS_BASE_LO: stg_d[sel_dir_q][wsel].base[DW-1:0]     = reg_wdata;
        OFS_BASE_HI: stg_d[sel_dir_q][wsel].base[AW-1:DW]    = reg_wdata;
        OFS_LIMIT:   stg_d[sel_dir_q][wsel].limit            = reg_wdata;
        OFS_TGT_LO:  stg_d[sel_dir_q][wsel].target[DW-1:0]   = reg_wdata;
        OFS_TGT_HI:  stg_d[sel_dir_q][wsel].target[AW-1:DW]  = reg_wdata;
        default: ;
      endcase
    end
  end

  // registers, write strobe as clock enable
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_dir_q <= 1'b0;
      sel_idx_q <= '0;
      for (int d = 0; d < 2; d++) begin
        for (int w = 0; w < NUM_WIN; w++) begin
          stg_q[d][w].base    <= '0;
          stg_q[d][w].limit   <= '1;
          stg_q[d][w].target  <= '0;
          stg_q[d][w].kind    <= '0;
          stg_q[d][w].ctrl    <= (d == 1 && w == 0) ? EN_MASK : '0;
          live_q[d][w].en     <= (d == 1 && w == 0);
          live_q[d][w].is_cfg <= 1'b0;
          live_q[d][w].base   <= '0;
          live_q[d][w].limit  <= '1;
          live_q[d][w].target <= '0;
        end
      end
    end else if (reg_we) begin
      sel_dir_q <= sel_dir_d;
      sel_idx_q <= sel_idx_d;
      stg_q     <= stg_d;
      live_q    <= live_d;
    end
  end

  // read mux
  always_comb begin
    reg_rdata = '0;
    if (reg_addr == OFS_SELECT) begin
      reg_rdata[DIR_BIT]   = sel_dir_q;
      reg_rdata[SEL_W-1:0] = sel_idx_q;
    end else if (sel_ok) begin
      case (reg_addr)
        OFS_TYPE:    reg_rdata = cur.kind;
        OFS_CTRL:    reg_rdata = cur.ctrl;
        OFS_BASE_LO: reg_rdata = cur.base[DW-1:0];
        OFS_BASE_HI: reg_rdata = cur.base[AW-1:DW];
        OFS_LIMIT:   reg_rdata = cur.limit;
        OFS_TGT_LO:  reg_rdata = cur.target[DW-1:0];
        OFS_TGT_HI:  reg_rdata = cur.target[AW-1:DW];
        default: ;
      endcase
    end
  end

  assign live_in  = live_q[1];
  assign live_out = live_q[0];

  // R4: committed windows move only on a control-word write
  a_r4_commit_only: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_we && reg_addr == OFS_CTRL) |=> $stable(live_q));

  // R11: window registers of a missing window read zero and hold
  a_r11_oob_read: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel_ok && win_reg) |-> (reg_rdata == '0));
  a_r11_oob_write: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && !sel_ok && reg_addr != OFS_SELECT) |=> ($stable(stg_q) && $stable(live_q)));

  // R12: unmapped offsets read zero and change nothing
  a_r12_unmapped_read: assert property (@(posedge clk) disable iff (!rst_n)
    (!win_reg && reg_addr != OFS_SELECT) |-> (reg_rdata == '0));
  a_r12_unmapped_write: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && !win_reg && reg_addr != OFS_SELECT) |=>
      ($stable(stg_q) && $stable(sel_idx_q) && $stable(sel_dir_q)));
endmodule

// File: rtl/axu_match.sv
module axu_match
  import axu_pkg::*;
#(
  parameter int unsigned NUM_WIN   = 4,
  parameter bit          OUTBOUND  = 1'b0,
  parameter int unsigned CFG_OFF_W = 12,
  localparam int unsigned WIN_W    = $clog2(NUM_WIN)
) (
  input  win_live_t [NUM_WIN-1:0] wins,
  input  logic [AW-1:0]           addr,
  output logic                    hit,
  output logic [WIN_W-1:0]        win,
  output logic                    cfg,
  output logic [AW-1:0]           xaddr,
  output logic [7:0]              bus,
  output logic [7:0]              devfn,
  output logic [CFG_OFF_W-1:0]    offset
);
  logic [NUM_WIN-1:0] match;

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
    logic [AW-1:0] top_addr;
    assign top_addr = {wins[w].base[AW-1:DW], wins[w].limit};
    assign match[w] = wins[w].en && (addr >= wins[w].base) && (addr <= top_addr);
  end

  // lowest index has priority
  always_comb begin
    win = '0;
    for (int w = NUM_WIN - 1; w >= 0; w--) begin
      if (match[w]) win = WIN_W'(w);
    end
  end

  win_live_t     sel;
  logic [AW-1:0] delta;

  assign hit    = |match;
  assign sel    = wins[win];
  assign delta  = addr - sel.base;
  assign cfg    = hit && OUTBOUND && sel.is_cfg;
  assign xaddr  = (hit && !cfg) ? (delta + sel.target) : '0;
  assign bus    = cfg ? sel.target[31:24] : '0;
  assign devfn  = cfg ? sel.target[23:16] : '0;
  assign offset = cfg ? delta[CFG_OFF_W-1:0] : '0;
endmodule

// File: rtl/addr_xlate_unit.sv
module addr_xlate_unit
  import axu_pkg::*;
#(
  parameter int unsigned NUM_WIN   = 4,
  parameter int unsigned SEL_W     = 4,
  parameter int unsigned CFG_OFF_W = 12,
  localparam int unsigned WIN_W    = $clog2(NUM_WIN)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 reg_we,
  input  logic [11:0]          reg_addr,
  input  logic [31:0]          reg_wdata,
  output logic [31:0]          reg_rdata,
  input  logic                 req_valid,
  input  logic                 req_inbound,
  input  logic [63:0]          req_addr,
  output logic                 rsp_valid,
  output logic                 rsp_hit,
  output logic [WIN_W-1:0]     rsp_win,
  output logic                 rsp_cfg,
  output logic [63:0]          rsp_addr,
  output logic [7:0]           rsp_bus,
  output logic [7:0]           rsp_devfn,
  output logic [CFG_OFF_W-1:0] rsp_offset
);
  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_pipe;
  logic       rst_ns;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_ns = rst_pipe[1];

  win_live_t [1:0][NUM_WIN-1:0] live;

  axu_regfile #(.NUM_WIN(NUM_WIN), .SEL_W(SEL_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_ns),
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .live_in   (live[1]),
    .live_out  (live[0])
  );

  logic [1:0]                m_hit, m_cfg;
  logic [1:0][WIN_W-1:0]     m_win;
  logic [1:0][63:0]          m_addr;
  logic [1:0][7:0]           m_bus, m_devfn;
  logic [1:0][CFG_OFF_W-1:0] m_off;

  for (genvar d = 0; d < 2; d++) begin : g_dir
    axu_match #(.NUM_WIN(NUM_WIN), .OUTBOUND(d == 0), .CFG_OFF_W(CFG_OFF_W)) u_match (
      .wins   (live[d]),
      .addr   (req_addr),
      .hit    (m_hit[d]),
      .win    (m_win[d]),
      .cfg    (m_cfg[d]),
      .xaddr  (m_addr[d]),
      .bus    (m_bus[d]),
      .devfn  (m_devfn[d]),
      .offset (m_off[d])
    );
  end

  // next state of the response register
  logic                 hit_d, cfg_d;
  logic [WIN_W-1:0]     win_d;
  logic [63:0]          addr_d;
  logic [7:0]           bus_d, devfn_d;
  logic [CFG_OFF_W-1:0] off_d;
  logic                 dir_q;

  always_comb begin
    hit_d   = 1'b0;
    cfg_d   = 1'b0;
    win_d   = '0;
    addr_d  = '0;
    bus_d   = '0;
    devfn_d = '0;
    off_d   = '0;
    if (req_valid) begin
      hit_d   = m_hit[req_inbound];
      cfg_d   = m_cfg[req_inbound];
      win_d   = m_win[req_inbound];
      addr_d  = m_addr[req_inbound];
      bus_d   = m_bus[req_inbound];
      devfn_d = m_devfn[req_inbound];
      off_d   = m_off[req_inbound];
      if (!m_hit[req_inbound]) win_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      rsp_valid  <= 1'b0;
      rsp_hit    <= 1'b0;
      rsp_cfg    <= 1'b0;
      rsp_win    <= '0;
      rsp_addr   <= '0;
      rsp_bus    <= '0;
      rsp_devfn  <= '0;
      rsp_offset <= '0;
      dir_q      <= 1'b0;
    end else begin
      rsp_valid  <= req_valid;
      rsp_hit    <= hit_d;
      rsp_cfg    <= cfg_d;
      rsp_win    <= win_d;
      rsp_addr   <= addr_d;
      rsp_bus    <= bus_d;
      rsp_devfn  <= devfn_d;
      rsp_offset <= off_d;
      dir_q      <= req_inbound;
    end
  end

  // R10: one-edge latency, idle edges give no result
  a_r10_latency: assert property (@(posedge clk) disable iff (!rst_ns)
    req_valid |=> rsp_valid);
  a_r10_idle: assert property (@(posedge clk) disable iff (!rst_ns)
    !req_valid |=> (!rsp_valid && !rsp_hit));

  // R9: a miss carries no stale fields
  a_r9_miss_zero: assert property (@(posedge clk) disable iff (!rst_ns)
    !rsp_hit |-> (rsp_addr == '0 && !rsp_cfg && rsp_win == '0 &&
                  rsp_bus == '0 && rsp_devfn == '0 && rsp_offset == '0));

  // R7: configuration results come only from outbound matches
  a_r7_cfg_outbound: assert property (@(posedge clk) disable iff (!rst_ns)
    rsp_cfg |-> (rsp_hit && !dir_q && rsp_addr == '0));
endmodule

// File: tb/tb_addr_xlate_unit.sv
`timescale 1ns/1ps
module tb_addr_xlate_unit;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_we;
  logic [11:0] reg_addr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic        req_valid, req_inbound;
  logic [63:0] req_addr;
  logic        rsp_valid, rsp_hit, rsp_cfg;
  logic [1:0]  rsp_win;
  logic [63:0] rsp_addr;
  logic [7:0]  rsp_bus, rsp_devfn;
  logic [11:0] rsp_offset;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk;   // 250 MHz

  addr_xlate_unit dut (
    .clk(clk), .rst_n(rst_n),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .req_valid(req_valid), .req_inbound(req_inbound), .req_addr(req_addr),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_win(rsp_win), .rsp_cfg(rsp_cfg),
    .rsp_addr(rsp_addr), .rsp_bus(rsp_bus), .rsp_devfn(rsp_devfn), .rsp_offset(rsp_offset)
  );

  task automatic chk(input string rq, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic rd_chk(input string rq, input logic [11:0] a, input logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    chk(rq, $sformatf("read %h", a), {32'h0, v}, {32'h0, exp});
  endtask

  task automatic pick(input bit inb, input logic [3:0] idx);
    wr(12'h900, {inb, 27'h0, idx});
  endtask

  task automatic prog(input bit inb, input logic [3:0] idx, input logic [63:0] base,
                      input logic [31:0] lim, input logic [63:0] tgt,
                      input logic [31:0] kind, input logic [31:0] ctl);
    pick(inb, idx);
    wr(12'h90C, base[31:0]);  wr(12'h910, base[63:32]);
    wr(12'h914, lim);
    wr(12'h918, tgt[31:0]);   wr(12'h91C, tgt[63:32]);
    wr(12'h904, kind);
    wr(12'h908, ctl);
  endtask

  // present one request; outputs hold its result at the next falling edge
  task automatic look(input bit inb, input logic [63:0] a);
    @(negedge clk);
    req_valid = 1'b1; req_inbound = inb; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic exp_rsp(input string rq, input bit hit, input logic [1:0] win,
                         input bit cfg, input logic [63:0] xa, input logic [7:0] bus,
                         input logic [7:0] dfn, input logic [11:0] off);
    chk(rq, "valid",  {63'h0, rsp_valid}, 64'h1);
    chk(rq, "hit",    {63'h0, rsp_hit},   {63'h0, hit});
    chk(rq, "win",    {62'h0, rsp_win},   {62'h0, win});
    chk(rq, "cfg",    {63'h0, rsp_cfg},   {63'h0, cfg});
    chk(rq, "addr",   rsp_addr, xa);
    chk(rq, "bus",    {56'h0, rsp_bus},   {56'h0, bus});
    chk(rq, "devfn",  {56'h0, rsp_devfn}, {56'h0, dfn});
    chk(rq, "offset", {52'h0, rsp_offset},{52'h0, off});
  endtask

  // window 1 memory model for the sweep
  localparam logic [63:0] W1_BASE = 64'h1000_0000;
  localparam logic [63:0] W1_LIM  = 64'h1FFF_FFFF;
  localparam logic [63:0] W1_TGT  = 64'h2_0000_0000;

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    rst_n = 1'b0; reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
    req_valid = 1'b0; req_inbound = 1'b0; req_addr = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R8: reset contents
    chk("R10", "idle valid", {63'h0, rsp_valid}, 64'h0);
    rd_chk("R8", 12'h900, 32'h0);
    pick(1'b1, 4'd0);
    rd_chk("R8", 12'h908, 32'h8000_0000);
    rd_chk("R8", 12'h914, 32'hFFFF_FFFF);
    rd_chk("R8", 12'h90C, 32'h0);
    rd_chk("R8", 12'h904, 32'h0);
    pick(1'b0, 4'd3);
    rd_chk("R8", 12'h908, 32'h0);
    rd_chk("R8", 12'h914, 32'hFFFF_FFFF);
    rd_chk("R8", 12'h91C, 32'h0);

    // R8: inbound pass-through, R9: misses
    look(1'b1, 64'h1234_5678);
    exp_rsp("R8", 1, 0, 0, 64'h1234_5678, 0, 0, 0);
    look(1'b1, 64'hFFFF_FFFF);
    exp_rsp("R8", 1, 0, 0, 64'hFFFF_FFFF, 0, 0, 0);
    look(1'b1, 64'h1_0000_0000);
    exp_rsp("R9", 0, 0, 0, 64'h0, 0, 0, 0);
    look(1'b0, 64'h1000);
    exp_rsp("R9", 0, 0, 0, 64'h0, 0, 0, 0);
    @(negedge clk);
    chk("R10", "valid after idle edge", {63'h0, rsp_valid}, 64'h0);
    chk("R10", "hit after idle edge",   {63'h0, rsp_hit},   64'h0);

    // R4: staged values are not used until the control word is written
    pick(1'b0, 4'd1);
    wr(12'h90C, W1_BASE[31:0]); wr(12'h910, W1_BASE[63:32]);
    wr(12'h914, W1_LIM[31:0]);
    wr(12'h918, W1_TGT[31:0]);  wr(12'h91C, W1_TGT[63:32]);
    wr(12'h904, 32'h0);
    look(1'b0, W1_BASE);
    exp_rsp("R4", 0, 0, 0, 64'h0, 0, 0, 0);
    wr(12'h908, 32'h8000_0000);

    // R5: sweep across both edges of window 1
    for (int i = 0; i < 40; i++) begin
      logic [63:0] a;
      bit h;
      a = W1_BASE - 64'h0200_0000 + 64'(i) * 64'h0080_0000;
      h = (a >= W1_BASE) && (a <= W1_LIM);
      look(1'b0, a);
      exp_rsp("R5", h, h ? 2'd1 : 2'd0, 0, h ? (a - W1_BASE + W1_TGT) : 64'h0, 0, 0, 0);
    end
    for (int e = 0; e < 6; e++) begin
      logic [63:0] a;
      bit h;
      case (e)
        0: a = W1_BASE - 1;  1: a = W1_BASE;     2: a = W1_BASE + 1;
        3: a = W1_LIM - 1;   4: a = W1_LIM;      default: a = W1_LIM + 1;
      endcase
      h = (a >= W1_BASE) && (a <= W1_LIM);
      look(1'b0, a);
      exp_rsp("R5", h, h ? 2'd1 : 2'd0, 0, h ? (a - W1_BASE + W1_TGT) : 64'h0, 0, 0, 0);
    end

    // R2: read-back, R3: half-word writes
    rd_chk("R2", 12'h90C, W1_BASE[31:0]);
    rd_chk("R2", 12'h914, W1_LIM[31:0]);
    rd_chk("R2", 12'h91C, W1_TGT[63:32]);
    rd_chk("R2", 12'h908, 32'h8000_0000);
    wr(12'h910, 32'h0000_00AB);
    rd_chk("R3", 12'h910, 32'h0000_00AB);
    rd_chk("R3", 12'h90C, W1_BASE[31:0]);
    wr(12'h918, 32'h0000_5000);
    rd_chk("R3", 12'h918, 32'h0000_5000);
    rd_chk("R3", 12'h91C, W1_TGT[63:32]);
    look(1'b0, W1_BASE + 64'h10);   // R4: still the committed window
    exp_rsp("R4", 1, 1, 0, W1_TGT + 64'h10, 0, 0, 0);
    wr(12'h910, W1_BASE[63:32]);
    wr(12'h918, W1_TGT[31:0]);

    // R6: overlap priority
    prog(1'b0, 4'd0, 64'h1800_0000, 32'h18FF_FFFF, 64'h5_0000_0000, 32'h0, 32'h8000_0000);
    prog(1'b0, 4'd3, 64'h1000_0000, 32'h1000_0FFF, 64'h7_0000_0000, 32'h0, 32'h8000_0000);
    look(1'b0, 64'h1880_0000);
    exp_rsp("R6", 1, 0, 0, 64'h5_0080_0000, 0, 0, 0);
    look(1'b0, 64'h1900_0000);
    exp_rsp("R6", 1, 1, 0, 64'h2_0900_0000, 0, 0, 0);
    look(1'b0, 64'h1000_0010);
    exp_rsp("R6", 1, 1, 0, 64'h2_0000_0010, 0, 0, 0);

    // R7: outbound configuration window sweep
    prog(1'b0, 4'd2, 64'h4000_0000, 32'h4000_FFFF, 64'h0308_0000, 32'h4, 32'h8000_0000);
    for (int i = 0; i < 16; i++) begin
      logic [63:0] d;
      d = 64'(i) * 64'h1111;
      look(1'b0, 64'h4000_0000 + d);
      exp_rsp("R7", 1, 2, 1, 64'h0, 8'h03, 8'h08, d[11:0]);
    end
    // R7: inbound ignores the type word; R5: top from base upper half
    prog(1'b1, 4'd1, 64'h2_0000_0000, 32'h0000_FFFF, 64'h8000, 32'h4, 32'h8000_0000);
    look(1'b1, 64'h2_0000_0100);
    exp_rsp("R7", 1, 1, 0, 64'h8100, 0, 0, 0);
    look(1'b1, 64'h2_0001_0000);
    exp_rsp("R5", 0, 0, 0, 64'h0, 0, 0, 0);

    // R11: index beyond the window count
    pick(1'b0, 4'd5);
    wr(12'h914, 32'h1234);
    wr(12'h908, 32'h0);
    rd_chk("R11", 12'h914, 32'h0);
    rd_chk("R11", 12'h908, 32'h0);
    pick(1'b0, 4'd1);
    rd_chk("R11", 12'h914, W1_LIM[31:0]);
    look(1'b0, 64'h1900_0000);
    exp_rsp("R11", 1, 1, 0, 64'h2_0900_0000, 0, 0, 0);

    // R1: selector keeps only its two fields
    wr(12'h900, 32'hFFFF_FFFF);
    rd_chk("R1", 12'h900, 32'h8000_000F);
    wr(12'h900, 32'h7FFF_FFF2);
    rd_chk("R1", 12'h900, 32'h0000_0002);

    // R12: unmapped offsets
    rd_chk("R12", 12'h800, 32'h0);
    wr(12'h920, 32'hFFFF_FFFF);
    rd_chk("R12", 12'h920, 32'h0);
    wr(12'h90E, 32'hFFFF_FFFF);
    rd_chk("R12", 12'h900, 32'h0000_0002);
    rd_chk("R12", 12'h90C, 32'h4000_0000);

    // R5: disabling window 1
    pick(1'b0, 4'd1);
    wr(12'h908, 32'h0);
    look(1'b0, 64'h1900_0000);
    exp_rsp("R5", 0, 0, 0, 64'h0, 0, 0, 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule